// File: doc/BRIEF.md
# Configurable PAL Output Macrocell

This block is one output cell of a small sum-of-products logic array. It receives the OR-ed sum term and a dedicated output-enable product term from the array. It drives a tri-stateable pin, which is modelled as a data output plus an enable output. It reads the resolved pin level back and returns feedback to the array in true and complement form.

A mode bit chooses between two paths. In the registered path a D flip-flop captures the sum term and drives the pin. In the combinational path the sum term goes straight to the pin. A polarity bit chooses whether the pin shows the true or the inverted value.

The feedback source depends on the mode. A registered cell feeds back its own inverted register state, so its pin can only act as an output. A combinational cell feeds back whatever level sits on the pin. When its driver is off, the pin can therefore serve as an input.

Top module: `pal_macrocell`

## Requirements
- R1: With mode_reg_i=1, the register captures sum_i on each rising clk_i edge, and pin_o changes only at that edge.
- R2: pol_high_i=1 makes pin_o carry the selected source unchanged, and pol_high_i=0 makes it carry the inverse. This applies in both modes.
- R3: With mode_reg_i=1, pin_oe_o follows oe_term_i in the same cycle.
- R4: With mode_reg_i=1, fb_o equals the inverted register state and fb_n_o equals the register state, whatever level pin_i carries.
- R5: With mode_reg_i=0, pin_o follows sum_i combinationally, with no clock edge needed.
- R6: With mode_reg_i=0, comb_oe_sel_i selects the enable as follows: 2'b00 gives always off, 2'b01 gives always on, 2'b10 gives oe_term_i, and 2'b11 is treated as off.
- R7: With mode_reg_i=0, fb_o equals pin_i and fb_n_o equals its inverse. An external level on a disabled pin therefore reaches the feedback.
- R8: rst_ni low clears the register asynchronously. clr_i high clears it at the next rising edge, and clr_i takes priority over capturing sum_i.
- R9: The register keeps capturing while pin_oe_o is low. Re-enabling the pin shows the last captured value.
- R10: mode_reg_i=1 selects the registered path and mode_reg_i=0 selects the combinational path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous register clear, active high |
| sum_i | input | 1 | Sum term from the array |
| oe_term_i | input | 1 | Output-enable product term |
| mode_reg_i | input | 1 | 1 registered, 0 combinational |
| pol_high_i | input | 1 | 1 active high, 0 active low |
| comb_oe_sel_i | input | 2 | Combinational-mode enable source |
| pin_i | input | 1 | Resolved pin level |
| pin_o | output | 1 | Pin drive value |
| pin_oe_o | output | 1 | Pin driver enable |
| fb_o | output | 1 | Feedback to array, true |
| fb_n_o | output | 1 | Feedback to array, complement |

## Verification
A synchronous clear and a sum-term capture can land on the same clock edge. The bench raises clr_i while sum_i is 1 and then reads pin_o after the edge, expecting 0. The second case to watch is the pin being disabled while the bench drives it from outside. The bench applies an opposite external level in both modes. A registered cell is judged correct if its feedback stays on the register value, and a combinational cell is judged correct if its feedback tracks the external level.

// File: rtl/pal_mc_pkg.sv
package pal_mc_pkg;
  typedef enum logic [1:0] {
    OE_OFF  = 2'b00,
    OE_ON   = 2'b01,
    OE_TERM = 2'b10,
    OE_RSVD = 2'b11
  } oe_src_e;
endpackage

// File: rtl/mc_reg.sv
module mc_reg #(
  parameter logic RST_Q = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);
  logic started;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o     <= RST_Q;
      started <= 1'b0;
    end else begin
      started <= 1'b1;
      if (clr_i) q_o <= RST_Q;
      else       q_o <= d_i;
    end
  end

  AST_REG_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started && !$past(clr_i)) |-> (q_o == $past(d_i))); // R1
  AST_SYNC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started && $past(clr_i)) |-> (q_o == RST_Q)); // R8
endmodule

// File: rtl/mc_out.sv
module mc_out
  import pal_mc_pkg::*;
(
  input  logic       mode_reg_i,
  input  logic       pol_high_i,
  input  logic [1:0] comb_oe_sel_i,
  input  logic       q_i,
  input  logic       sum_i,
  input  logic       oe_term_i,
  output logic       pin_o,
  output logic       pin_oe_o
);
  logic    src;
  oe_src_e oe_src;

  assign src    = mode_reg_i ? q_i : sum_i;
  assign pin_o  = pol_high_i ? src : ~src;
  assign oe_src = oe_src_e'(comb_oe_sel_i);

  always_comb begin
    if (mode_reg_i) begin
      pin_oe_o = oe_term_i;
    end else begin
      unique case (oe_src)
        OE_ON:   pin_oe_o = 1'b1;
        OE_TERM: pin_oe_o = oe_term_i;
        default: pin_oe_o = 1'b0; // off and reserved
      endcase
    end
  end
endmodule

// File: rtl/mc_fb.sv
module mc_fb (
  input  logic mode_reg_i,
  input  logic q_i,
  input  logic pin_i,
  output logic fb_o,
  output logic fb_n_o
);
  logic raw;

  // registered: feed back /Q, pin is ignored
  assign raw    = mode_reg_i ? ~q_i : pin_i;
  assign fb_o   = raw;
  assign fb_n_o = ~raw;
endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell #(
  parameter logic RST_Q = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       sum_i,
  input  logic       oe_term_i,
  input  logic       mode_reg_i,
  input  logic       pol_high_i,
  input  logic [1:0] comb_oe_sel_i,
  input  logic       pin_i,
  output logic       pin_o,
  output logic       pin_oe_o,
  output logic       fb_o,
  output logic       fb_n_o
);
  logic q;

  mc_reg #(.RST_Q(RST_Q)) u_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_i),
    .d_i   (sum_i),
    .q_o   (q)
  );

  mc_out u_out (
    .mode_reg_i   (mode_reg_i),
    .pol_high_i   (pol_high_i),
    .comb_oe_sel_i(comb_oe_sel_i),
    .q_i          (q),
    .sum_i        (sum_i),
    .oe_term_i    (oe_term_i),
    .pin_o        (pin_o),
    .pin_oe_o     (pin_oe_o)
  );

  mc_fb u_fb (
    .mode_reg_i(mode_reg_i),
    .q_i       (q),
    .pin_i     (pin_i),
    .fb_o      (fb_o),
    .fb_n_o    (fb_n_o)
  );

  AST_REG_FB_TRACKS_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_reg_i && pol_high_i) |-> (fb_n_o == pin_o)); // R4
  AST_REG_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_reg_i |-> (pin_oe_o == oe_term_i)); // R3
  AST_COMB_PATH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_reg_i |-> (pin_o == (pol_high_i ? sum_i : !sum_i))); // R5
  AST_COMB_OE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_reg_i && comb_oe_sel_i[1] == comb_oe_sel_i[0]) |-> !pin_oe_o); // R6
endmodule

// File: tb/pal_macrocell_bench.sv
module pal_macrocell_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clr_i = 1'b0;
  logic       sum_i = 1'b0;
  logic       oe_term_i = 1'b1;
  logic       mode_reg_i = 1'b1;
  logic       pol_high_i = 1'b1;
  logic [1:0] comb_oe_sel_i = 2'b01;
  logic       ext_lvl = 1'b0;
  logic       pin_i;
  logic       pin_o, pin_oe_o, fb_o, fb_n_o;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #10 clk_i = ~clk_i; // 50 MHz

  assign pin_i = pin_oe_o ? pin_o : ext_lvl;

  pal_macrocell u_pal_macrocell (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .sum_i(sum_i),
    .oe_term_i(oe_term_i), .mode_reg_i(mode_reg_i), .pol_high_i(pol_high_i),
    .comb_oe_sel_i(comb_oe_sel_i), .pin_i(pin_i), .pin_o(pin_o),
    .pin_oe_o(pin_oe_o), .fb_o(fb_o), .fb_n_o(fb_n_o)
  );

  task automatic chk(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b", req, got, exp);
    end
  endtask

  task automatic clk_in(input logic v);
    @(negedge clk_i);
    sum_i = v;
    @(posedge clk_i);
    #1;
  endtask

  task automatic t_reset;
    mode_reg_i = 1; pol_high_i = 1; oe_term_i = 1;
    #1;
    chk(pin_o, 1'b0, "R8 reset pin");
    chk(fb_o, 1'b1, "R8 reset fb");
    @(negedge clk_i); rst_ni = 1;
  endtask

  task automatic t_reg_capture;
    logic prev;
    mode_reg_i = 1; pol_high_i = 1; oe_term_i = 1;
    prev = 1'b0;
    for (int i = 0; i < 4; i++) begin
      logic v;
      v = (i % 2 == 0);
      @(negedge clk_i); sum_i = v; #1;
      chk(pin_o, prev, "R1 hold before edge");
      @(posedge clk_i); #1;
      chk(pin_o, v, "R1 capture");
      chk(fb_o, ~v, "R4 fb");
      chk(fb_n_o, v, "R4 fb_n");
      prev = v;
    end
  endtask

  task automatic t_reg_pol;
    mode_reg_i = 1; pol_high_i = 0;
    clk_in(1'b1);
    chk(pin_o, 1'b0, "R2 reg low pol");
    clk_in(1'b0);
    chk(pin_o, 1'b1, "R2 reg low pol");
    pol_high_i = 1;
  endtask

  task automatic t_reg_oe;
    mode_reg_i = 1;
    oe_term_i = 0; #1;
    chk(pin_oe_o, 1'b0, "R3 oe term 0");
    oe_term_i = 1; #1;
    chk(pin_oe_o, 1'b1, "R3 oe term 1");
  endtask

  task automatic t_reg_fb_ext;
    mode_reg_i = 1; pol_high_i = 1;
    clk_in(1'b0);
    oe_term_i = 0; ext_lvl = 1; #1;
    chk(fb_o, 1'b1, "R4 ignore ext pin");
    chk(fb_n_o, 1'b0, "R4 ignore ext pin");
    clk_in(1'b1);
    ext_lvl = 0; #1;
    chk(fb_o, 1'b0, "R9 capture while disabled");
    oe_term_i = 1; #1;
    chk(pin_o, 1'b1, "R9 value after re-enable");
  endtask

  task automatic t_clear;
    mode_reg_i = 1; pol_high_i = 1;
    clk_in(1'b1);
    @(negedge clk_i); clr_i = 1; sum_i = 1;
    @(posedge clk_i); #1;
    chk(pin_o, 1'b0, "R8 clear beats capture");
    @(negedge clk_i); clr_i = 0;
    @(posedge clk_i); #1;
    chk(pin_o, 1'b1, "R8 capture after clear");
  endtask

  task automatic t_comb_path;
    mode_reg_i = 0; comb_oe_sel_i = 2'b01;
    @(negedge clk_i);
    for (int p = 0; p < 2; p++) begin
      pol_high_i = p[0];
      for (int s = 0; s < 2; s++) begin
        sum_i = s[0]; #1;
        chk(pin_o, s[0] ^ ~p[0], "R5 R2 R10 comb path");
      end
    end
    pol_high_i = 1;
  endtask

  task automatic t_comb_oe;
    mode_reg_i = 0;
    for (int t = 0; t < 2; t++) begin
      oe_term_i = t[0];
      comb_oe_sel_i = 2'b00; #1; chk(pin_oe_o, 1'b0, "R6 sel 00");
      comb_oe_sel_i = 2'b01; #1; chk(pin_oe_o, 1'b1, "R6 sel 01");
      comb_oe_sel_i = 2'b10; #1; chk(pin_oe_o, t[0], "R6 sel 10");
      comb_oe_sel_i = 2'b11; #1; chk(pin_oe_o, 1'b0, "R6 sel 11");
    end
    oe_term_i = 1;
  endtask

  task automatic t_comb_fb;
    mode_reg_i = 0; comb_oe_sel_i = 2'b00; sum_i = 0;
    ext_lvl = 1; #1;
    chk(fb_o, 1'b1, "R7 ext high");
    chk(fb_n_o, 1'b0, "R7 ext high");
    ext_lvl = 0; #1;
    chk(fb_o, 1'b0, "R7 ext low");
    comb_oe_sel_i = 2'b01; sum_i = 1; ext_lvl = 0; #1;
    chk(fb_o, 1'b1, "R7 driven pin");
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    t_reset();
    t_reg_capture();
    t_reg_pol();
    t_reg_oe();
    t_reg_fb_ext();
    t_clear();
    t_comb_path();
    t_comb_oe();
    t_comb_fb();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog got timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule